// File: doc/BRIEF.md
# Dual Comparator Output Logic Unit

This block post-processes two comparator results that are already synchronized to the clock. Each of the two channels has a programmable two-input logic function and an edge-set latch. Three output paths per channel then carry either the raw function result or the latched value onward. The first path is the main result, used by sense and interrupt logic downstream. The second is a result that can be routed to a pin. The third is an enable for the analog bus.

Two 8-bit read/write registers on a simple synchronous register bus hold all configuration. A channel latch is set when its own function output rises. It is cleared from one of two selectable sources: any write to the control register, or a rising edge of the other channel's function output. The second source joins the two channels into a start/stop window detector.

For each channel the function input A is that channel's own comparator and input B is the opposite comparator.

Top module: `dual_cmp_logic`

## Requirements
- R1: After reset both registers read 0x00, every latch is clear, and with both comparator inputs low all outputs are 0.
- R2: A write at address CTRL_ADDR loads the control register. A write at CTRL_ADDR+1 loads the function register. A read at either address returns the register's current value with no wait cycle. Any other address reads 0x00, and a write to it changes no register.
- R3: The function register holds channel 1's code in bits 7..4 and channel 0's code in bits 3..0. A channel's function output equals code bit (3 - {A,B}) and follows the inputs combinationally. Examples: 0h gives 0, Fh gives 1, 6h gives XOR, Eh gives NAND, 3h gives A.
- R4: A channel latch sets at the clock edge that ends a cycle in which its own function output is 1 and was 0 in the previous cycle. Otherwise it holds until it is cleared.
- R5: The control register holds channel 1's nibble in bits 7..4 and channel 0's nibble in bits 3..0. Nibble bit 1 is the clear-source select. When that bit is 0, any control register write clears the latch at the write's clock edge, and the select value in force is the one held before the write.
- R6: When nibble bit 1 is 1, the latch clears at the clock edge that ends a cycle in which the opposite channel's function output rose, and control register writes do not clear it.
- R7: When a set and a clear of the same latch fall in the same cycle, the latch ends clear.
- R8: Nibble bit 0 picks the source of the main output: 0 selects the function output, 1 selects the latch. Nibble bit 2 picks the source of the pin output in the same way, and is independent of bit 0.
- R9: Nibble bit 3 drives the channel's analog-bus enable directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 2 | Synchronized comparator results, bit i for channel i |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| main_out | output | 2 | Main result per channel |
| pin_out | output | 2 | Pin-routable result per channel |
| abus_en | output | 2 | Analog-bus enable per channel |

## Verification
A latch can be set and cleared in the same cycle. One case is its own function output rising on the same edge as the opposite channel's output while cross-clearing is selected. The other is its own output rising during a control register write while write-clearing is selected. The bench arranges both with directed input pairs and codes, and random traffic that mixes writes with input toggles hits them again many times. A reference model computes the result, and the latched output must read clear in the next cycle.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  localparam int NCH    = 2;
  localparam int CODE_W = 4;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic abus_en;
    logic pin_sel;
    logic clr_src;
    logic main_sel;
  } chan_cfg_t;

  function automatic logic lut_eval(input logic [CODE_W-1:0] code,
                                    input logic a, input logic b);
    logic [1:0] idx;
    idx = ~{a, b};
    return code[idx];
  endfunction
endpackage

// File: rtl/dcl_rst_sync.sv
module dcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcl_regs.sv
module dcl_regs #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] lut_q,
  output logic              ctrl_wr
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_LUT  = ADDR_W'(CTRL_ADDR) + ADDR_W'(1);

  logic              hit_ctrl, hit_lut;
  logic              lut_wr;
  logic [DATA_W-1:0] ctrl_d, lut_d;

  always_comb begin
    hit_ctrl = (bus_addr == A_CTRL);
    hit_lut  = (bus_addr == A_LUT);
    ctrl_wr  = bus_wr && hit_ctrl;
    lut_wr   = bus_wr && hit_lut;
    ctrl_d   = ctrl_wr ? bus_wdata : ctrl_q;
    lut_d    = lut_wr  ? bus_wdata : lut_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lut_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (lut_wr)  lut_q  <= lut_d;
    end
  end

  always_comb begin
    if (hit_ctrl)     bus_rdata = ctrl_q;
    else if (hit_lut) bus_rdata = lut_q;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/dcl_chan.sv
module dcl_chan
  import dcl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic [CODE_W-1:0] code,
  input  chan_cfg_t         cfg,
  input  logic              ctrl_wr,
  input  logic              opp_rise,
  output logic              lut_o,
  output logic              rise_o,
  output logic              clr_o,
  output logic              latch_o,
  output logic              main_o,
  output logic              pin_o,
  output logic              abus_o
);
  logic lut_prev_q, lut_prev_d;
  logic latch_q, latch_d;

  always_comb begin
    lut_o      = lut_eval(code, in_a, in_b);
    rise_o     = lut_o && !lut_prev_q;
    clr_o      = cfg.clr_src ? opp_rise : ctrl_wr;
    lut_prev_d = lut_o;
    if (clr_o)       latch_d = 1'b0;
    else if (rise_o) latch_d = 1'b1;
    else             latch_d = latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_prev_q <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      lut_prev_q <= lut_prev_d;
      latch_q    <= latch_d;
    end
  end

  always_comb begin
    latch_o = latch_q;
    main_o  = cfg.main_sel ? latch_q : lut_o;
    pin_o   = cfg.pin_sel  ? latch_q : lut_o;
    abus_o  = cfg.abus_en;
  end
endmodule

// File: rtl/dual_cmp_logic.sv
module dual_cmp_logic
  import dcl_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] CTRL_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmp_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    main_out,
  output logic [NCH-1:0]    pin_out,
  output logic [NCH-1:0]    abus_en
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] ctrl_q, lut_q;
  logic              ctrl_wr;
  logic [NCH-1:0]    lut_o, rise, clr, latch;

  dcl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dcl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .lut_q(lut_q), .ctrl_wr(ctrl_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg = chan_cfg_t'(ctrl_q[i*NIB_W +: NIB_W]);

    dcl_chan u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .in_a(cmp_in[i]), .in_b(cmp_in[NCH-1-i]),
      .code(lut_q[i*CODE_W +: CODE_W]),
      .cfg(cfg), .ctrl_wr(ctrl_wr), .opp_rise(rise[NCH-1-i]),
      .lut_o(lut_o[i]), .rise_o(rise[i]), .clr_o(clr[i]), .latch_o(latch[i]),
      .main_o(main_out[i]), .pin_o(pin_out[i]), .abus_o(abus_en[i])
    );
  end
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk #(
  parameter logic [7:0] CTRL_ADDR = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] ctrl_q,
  input logic [7:0] lut_q,
  input logic [1:0] lut_o,
  input logic [1:0] rise,
  input logic [1:0] clr,
  input logic [1:0] latch
);
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR) |=> ctrl_q == $past(bus_wdata)); // R2
  AST_LUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR + 8'd1) |=> lut_q == $past(bus_wdata)); // R2

  for (genvar i = 0; i < 2; i++) begin : g_chk
    AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_q[i*4 +: 4] == 4'h0) |-> !lut_o[i]); // R3
    AST_CODE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (lut_q[i*4 +: 4] == 4'hF) |-> lut_o[i]); // R3
    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !clr[i]) |=> latch[i]); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise[i] && !clr[i]) |=> latch[i] == $past(latch[i])); // R4
    AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_ADDR && !ctrl_q[i*4+1]) |=> !latch[i]); // R5
    AST_CROSS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[i*4+1] && rise[1-i]) |=> !latch[i]); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && rise[i]) |=> !latch[i]); // R7
  end
endmodule

bind dual_cmp_logic dcl_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .ctrl_q(ctrl_q), .lut_q(lut_q), .lut_o(lut_o), .rise(rise),
  .clr(clr), .latch(latch)
);

// File: tb/dual_cmp_logic_test.sv
module dual_cmp_logic_test;
  localparam logic [7:0] CA = 8'h20;
  localparam logic [7:0] LA = 8'h21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_in = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] main_out, pin_out, abus_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_ctrl, m_lut;
  logic [1:0] m_latch, m_prev;

  always #10 clk = ~clk;

  dual_cmp_logic uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .main_out(main_out), .pin_out(pin_out), .abus_en(abus_en)
  );

  function automatic logic fn(input logic [3:0] c, input logic a, input logic b);
    case ({a, b})
      2'b00:   return c[3];
      2'b01:   return c[2];
      2'b10:   return c[1];
      default: return c[0];
    endcase
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, check outputs mid-cycle, advance model over the edge
  task automatic step(input string tag, input logic [1:0] c, input logic wr,
                      input logic [7:0] a, input logic [7:0] d);
    logic [1:0] l, r, cl, em, ep, ea;
    logic [7:0] er;
    cmp_in = c; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #2;
    l[0] = fn(m_lut[3:0], c[0], c[1]);
    l[1] = fn(m_lut[7:4], c[1], c[0]);
    for (int i = 0; i < 2; i++) begin
      em[i] = m_ctrl[i*4]   ? m_latch[i] : l[i];
      ep[i] = m_ctrl[i*4+2] ? m_latch[i] : l[i];
      ea[i] = m_ctrl[i*4+3];
    end
    er = (a == CA) ? m_ctrl : (a == LA) ? m_lut : 8'h00;
    check(tag, {main_out, pin_out, abus_en, bus_rdata}, {em, ep, ea, er});
    r = l & ~m_prev;
    for (int i = 0; i < 2; i++) begin
      cl[i] = m_ctrl[i*4+1] ? r[1-i] : (wr && a == CA);
      if (cl[i])     m_latch[i] = 1'b0;
      else if (r[i]) m_latch[i] = 1'b1;
    end
    m_prev = l;
    if (wr && a == CA) m_ctrl = d;
    if (wr && a == LA) m_lut = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_lut = '0; m_latch = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    step("R1", 2'b00, 1'b0, CA, 8'h00);
    step("R1", 2'b00, 1'b0, LA, 8'h00);
    // R2: load, read back, foreign address
    step("R2", 2'b00, 1'b1, CA, 8'h5A);
    step("R2", 2'b00, 1'b0, CA, 8'h00);
    step("R2", 2'b00, 1'b1, 8'h22, 8'hFF);
    step("R2", 2'b00, 1'b0, 8'h22, 8'h00);
    step("R2", 2'b00, 1'b0, CA, 8'h00);
    step("R2", 2'b00, 1'b1, CA, 8'h00);
    // R3: XOR on ch0, NAND on ch1, then A and const one
    step("R3", 2'b00, 1'b1, LA, 8'hE6);
    for (int v = 0; v < 4; v++) step("R3", 2'(v), 1'b0, CA, 8'h00);
    step("R3", 2'b00, 1'b1, LA, 8'hF3);
    for (int v = 0; v < 4; v++) step("R3", 2'(v), 1'b0, LA, 8'h00);
    // R4 R8 R9: ch0 code A, main from latch, pin from function, analog on
    step("R8", 2'b00, 1'b1, CA, 8'h09);
    step("R4", 2'b01, 1'b0, CA, 8'h00);
    step("R4", 2'b00, 1'b0, CA, 8'h00);
    step("R9", 2'b00, 1'b0, CA, 8'h00);
    // R5: write clears with old select 0
    step("R5", 2'b00, 1'b1, CA, 8'h0B);
    step("R5", 2'b01, 1'b0, CA, 8'h00);
    step("R5", 2'b01, 1'b1, CA, 8'h0B);
    step("R5", 2'b00, 1'b0, CA, 8'h00);
    // R6/R7: ch1 code A; ch0 cross cleared
    step("R6", 2'b00, 1'b1, LA, 8'h33);
    step("R6", 2'b01, 1'b0, CA, 8'h00);
    step("R6", 2'b11, 1'b0, CA, 8'h00);
    step("R6", 2'b00, 1'b0, CA, 8'h00);
    step("R7", 2'b11, 1'b0, CA, 8'h00);
    step("R7", 2'b11, 1'b0, CA, 8'h00);
    // R7: own rise during a clearing write
    step("R7", 2'b00, 1'b1, CA, 8'h05);
    step("R7", 2'b01, 1'b1, CA, 8'h05);
    step("R7", 2'b01, 1'b0, CA, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic       w;
      w = ($urandom % 5) == 0;
      case ($urandom % 4)
        0: a = CA; 1: a = LA; 2: a = 8'($urandom); default: a = CA;
      endcase
      step("R8", 2'($urandom), w, a, 8'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule